// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software-facing logic writes a byte with a one-cycle write strobe. The byte lands in a single holding buffer that sits in front of the shift register. The block derives its bit timing from the system clock through a fixed-point divisor with a 12-bit integer part and a 4-bit fraction. Each bit is split into 16 sub-ticks. The fractional remainder is carried from sub-tick to sub-tick, so every whole bit lasts exactly `16 * divisor` clock cycles.

Besides data frames, the block produces two other kinds of frame:
- an all-ones idle frame, sent automatically each time the transmitter is switched on;
- a break frame, sent on request.

The stop length can be one of four values. An inversion control flips the serial line. Two flags report progress:
- `tbe` says the holding buffer can take a new byte;
- `tc` says the line has gone quiet with nothing left to send.

`tc` can also drive an interrupt.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset `txd` is high (with `tx_inv` low), `tbe` is 1, and `tc` and `irq` are 0.
- R2: A data frame is a low start bit, then 8 data bits with the least significant bit first, then high stop time.
- R3: With divisor value D (integer part in `baud_div[15:4]`, fraction in `baud_div[3:0]`), every whole bit lasts exactly 16*D clock cycles, fractional D included. A data frame with one stop bit therefore lasts 160*D cycles.
- R4: When `tx_en` rises, one all-high frame of a data frame's length is sent before any data or break frame.
- R5: A write clears `tbe` on the next edge. Moving the byte into the shift register sets `tbe` again, so a write to an idle, enabled transmitter holds `tbe` low for exactly one cycle.
- R6: A byte written while a frame is being sent stays in the buffer (`tbe` low) and starts on the very cycle the current frame ends, with no gap.
- R7: `tc` is set when a frame ends and the buffer is empty. A write clears it. `irq` equals `tc` AND `irq_en`.
- R8: `stop_sel` selects the stop time: 00 = 1 bit, 01 = 0.5 bit, 10 = 2 bits, 11 = 1.5 bits. Fractional stops are timed in sixteenths of a bit.
- R9: A pulse on `brk_req` queues a break frame: 9 bit times low, then the selected stop time high. A queued break goes ahead of a buffered byte. The idle frame goes ahead of both.
- R10: With `tx_inv` high, `txd` is the bitwise complement of the normal line, so it rests low.
- R11: While `tx_en` is low no frame starts, and a written byte waits in the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; a rising edge queues an idle frame |
| tx_inv | input | 1 | Invert the serial output |
| stop_sel | input | 2 | Stop time code (see R8) |
| brk_req | input | 1 | One-cycle request for a break frame |
| baud_div | input | 16 | Bit-time divisor, 12.4 fixed point |
| irq_en | input | 1 | Enables `irq` from `tc` |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line |
| tbe | output | 1 | Holding buffer is empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters: 8 data bits, 4 fraction bits, and a combinational interrupt. At run time it drives divisors of 2.0 and 2.5. These keep a frame between 288 and 400 cycles, so every stop code, the break, the back-to-back hand-off and the disabled-queue case fit inside a short run, and each can be timed to the exact cycle. The 2.5 setting makes the fraction carry on every other sub-tick, which tests that a whole bit comes out at exactly 40 cycles.

// File: rtl/uart_dtx_pkg.sv
package uart_dtx_pkg;

   typedef enum logic [1:0] {
      FRM_DATA  = 2'd0,
      FRM_IDLE  = 2'd1,
      FRM_BREAK = 2'd2
   } frm_kind_e;

   // stop time in sub-ticks for a stop code; ovs sub-ticks make one bit
   function automatic int stop_subticks(input logic [1:0] sel, input int ovs);
      case (sel)
         2'b00:   return ovs;
         2'b01:   return ovs / 2;
         2'b10:   return 2 * ovs;
         default: return ovs + ovs / 2;
      endcase
   endfunction

endpackage

// File: rtl/uart_dtx_baud.sv
module uart_dtx_baud #(
   parameter int INT_W  = 12,
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick
);
   localparam int PW = INT_W + 1;

   logic [PW-1:0]     cnt;
   logic [PW-1:0]     period;
   logic [PW-1:0]     base;
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W-1:0] acc_nxt;
   logic              carry;

   always_comb {carry, acc_nxt} = {1'b0, acc} + {1'b0, div_frac};

   // integer part of zero is treated as one
   always_comb base = (div_int == '0) ? PW'(1) : {1'b0, div_int};
   always_comb period = base + PW'(carry);

   assign tick = run & (cnt == period - PW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         acc <= '0;
      end else if (!run) begin
         cnt <= '0;
         acc <= '0;
      end else if (tick) begin
         cnt <= '0;
         acc <= restart ? '0 : acc_nxt;
      end else begin
         cnt <= cnt + PW'(1);
      end
   end

   // R3
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (|div_int[INT_W-1:1])) |=> !tick);

endmodule

// File: rtl/uart_dtx_shift.sv
module uart_dtx_shift
   import uart_dtx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  frm_kind_e         kind,
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        stop_sel,
   input  logic              tick,
   output logic              busy,
   output logic              done,
   output logic              line
);
   localparam int OVS  = 1 << FRAC_W;
   localparam int BODY = (DATA_W + 1) * OVS;
   localparam int MAXF = BODY + 2 * OVS;
   localparam int CW   = $clog2(MAXF);
   localparam int SW   = DATA_W + 1;

   logic [CW-1:0] sub_cnt;
   logic [CW-1:0] last_idx;
   logic [CW-1:0] last_nxt;
   logic [SW-1:0] sr;
   logic [SW-1:0] sr_init;
   logic          bit_edge;

   always_comb last_nxt = CW'(BODY + stop_subticks(stop_sel, OVS) - 1);

   always_comb begin
      case (kind)
         FRM_DATA: sr_init = {data, 1'b0};
         FRM_IDLE: sr_init = '1;
         default:  sr_init = '0;
      endcase
   end

   assign bit_edge = &sub_cnt[FRAC_W-1:0];
   assign done     = busy & tick & (sub_cnt == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sub_cnt  <= '0;
         last_idx <= '0;
         sr       <= '1;
      end else if (start) begin
         busy     <= 1'b1;
         sub_cnt  <= '0;
         last_idx <= last_nxt;
         sr       <= sr_init;
      end else if (done) begin
         busy     <= 1'b0;
         sub_cnt  <= '0;
      end else if (busy && tick) begin
         sub_cnt <= sub_cnt + CW'(1);
         if (bit_edge) sr <= {1'b1, sr[SW-1:1]};
      end
   end

   assign line = busy ? sr[0] : 1'b1;

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && kind != FRM_IDLE) |=> !line);
   // R4
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && kind == FRM_IDLE) |=> line);

endmodule

// File: rtl/uart_dtx_sched.sv
module uart_dtx_sched
   import uart_dtx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              brk_req,
   input  logic              busy,
   input  logic              done,
   output logic              start,
   output frm_kind_e         kind,
   output logic [DATA_W-1:0] data,
   output logic              tbe,
   output logic              tc
);
   logic en_q;
   logic idle_pend;
   logic brk_pend;
   logic valid;
   logic rise;
   logic want_idle;
   logic free;

   assign rise      = tx_en & ~en_q;
   assign want_idle = idle_pend | rise;
   assign free      = ~busy | done;
   assign start     = tx_en & free & (want_idle | brk_pend | valid);

   always_comb begin
      if (want_idle)     kind = FRM_IDLE;
      else if (brk_pend) kind = FRM_BREAK;
      else               kind = FRM_DATA;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         idle_pend <= 1'b0;
         brk_pend  <= 1'b0;
         valid     <= 1'b0;
         data      <= '0;
         tc        <= 1'b0;
      end else begin
         en_q <= tx_en;
         if (!tx_en)                          idle_pend <= 1'b0;
         else if (start && kind == FRM_IDLE)  idle_pend <= 1'b0;
         else if (rise)                       idle_pend <= 1'b1;
         if (brk_req)                         brk_pend <= 1'b1;
         else if (start && kind == FRM_BREAK) brk_pend <= 1'b0;
         if (wr_en) begin
            valid <= 1'b1;
            data  <= wr_data;
         end else if (start && kind == FRM_DATA) begin
            valid <= 1'b0;
         end
         if (wr_en)              tc <= 1'b0;
         else if (done && !valid) tc <= 1'b1;
      end
   end

   assign tbe = ~valid;

   // R5
   tbe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tbe);
   // R7
   tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tc);
   // R6
   hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tbe && busy && !done) |=> !tbe);

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
   import uart_dtx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DIV_INT_W  = 12,
   parameter int DIV_FRAC_W = 4,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tx_en,
   input  logic                            tx_inv,
   input  logic [1:0]                      stop_sel,
   input  logic                            brk_req,
   input  logic [DIV_INT_W+DIV_FRAC_W-1:0] baud_div,
   input  logic                            irq_en,
   input  logic                            wr_en,
   input  logic [DATA_W-1:0]               wr_data,
   output logic                            txd,
   output logic                            tbe,
   output logic                            tc,
   output logic                            irq
);
   localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;

   initial begin
      width_ok_chk: assert (DATA_W >= 5 && DATA_W <= 9)
         else $error("DATA_W out of range");
      frac_ok_chk: assert (DIV_FRAC_W >= 1 && DIV_FRAC_W <= 6)
         else $error("DIV_FRAC_W out of range");
      int_ok_chk: assert (DIV_INT_W >= 2)
         else $error("DIV_INT_W too small");
   end

   logic [DIV_INT_W-1:0]  div_int;
   logic [DIV_FRAC_W-1:0] div_frac;
   logic                  start;
   frm_kind_e             kind;
   logic [DATA_W-1:0]     sh_data;
   logic                  busy;
   logic                  done;
   logic                  tick;
   logic                  line;

   assign div_int  = baud_div[DIV_W-1:DIV_FRAC_W];
   assign div_frac = baud_div[DIV_FRAC_W-1:0];

   uart_dtx_sched #(.DATA_W(DATA_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en),
      .wr_data(wr_data), .brk_req(brk_req), .busy(busy), .done(done),
      .start(start), .kind(kind), .data(sh_data), .tbe(tbe), .tc(tc)
   );

   uart_dtx_baud #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .restart(start),
      .div_int(div_int), .div_frac(div_frac), .tick(tick)
   );

   uart_dtx_shift #(.DATA_W(DATA_W), .FRAC_W(DIV_FRAC_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
      .data(sh_data), .stop_sel(stop_sel), .tick(tick),
      .busy(busy), .done(done), .line(line)
   );

   assign txd = line ^ tx_inv;

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= tc & irq_en;
         end
      end else begin : g_irq_comb
         assign irq = tc & irq_en;
      end
   endgenerate

   // R10
   txd_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (txd == ~tx_inv));

endmodule

// File: tb/tb_uart_dbuf_tx.sv
module tb_uart_dbuf_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b0;
   logic        tx_inv = 1'b0;
   logic [1:0]  stop_sel = 2'b00;
   logic        brk_req = 1'b0;
   logic [15:0] baud_div = 16'h0020;
   logic        irq_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        txd, tbe, tc, irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   uart_dbuf_tx dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_inv(tx_inv),
      .stop_sel(stop_sel), .brk_req(brk_req), .baud_div(baud_div),
      .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data),
      .txd(txd), .tbe(tbe), .tc(tc), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_byte(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      int g = 0;
      @(negedge clk);
      while (!(tc === 1'b1 && tbe === 1'b1) && g < 5000) begin
         @(negedge clk);
         g++;
      end
   endtask

   task automatic rx_byte(input int bitp, input logic inv, output logic [7:0] b,
                          output int t_low, output logic stop_ok);
      int g = 0;
      b = 8'h00;
      @(negedge clk);
      while ((txd ^ inv) !== 1'b0 && g < 20000) begin
         @(negedge clk);
         g++;
      end
      t_low = cyc;
      repeat (bitp / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         repeat (bitp) @(negedge clk);
         b[i] = txd ^ inv;
      end
      repeat (bitp) @(negedge clk);
      stop_ok = ((txd ^ inv) == 1'b1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(txd == 1'b1, "R1 txd at reset", txd, 1);
      chk(tbe == 1'b1, "R1 tbe at reset", tbe, 1);
      chk(tc == 1'b0, "R1 tc at reset", tc, 0);
      chk(irq == 1'b0, "R1 irq at reset", irq, 0);
   endtask

   task automatic t_idle_frame();
      int k = 0;
      bit low_seen = 0;
      irq_en = 1'b1;
      @(negedge clk);
      tx_en = 1'b1;
      while (k < 1000) begin
         @(negedge clk);
         k++;
         if (txd == 1'b0) low_seen = 1;
         if (tc == 1'b1) break;
      end
      chk(k == 321, "R4 idle frame length", k, 321);
      chk(!low_seen, "R4 idle frame stays high", low_seen, 0);
      chk(irq == 1'b1, "R7 irq with tc and irq_en", irq, 1);
   endtask

   task automatic t_data_frame();
      logic [7:0] b;
      int t;
      logic s;
      write_byte(8'hA5);
      chk(tbe == 1'b0, "R5 tbe low after write", tbe, 0);
      chk(tc == 1'b0, "R7 tc cleared by write", tc, 0);
      chk(irq == 1'b0, "R7 irq follows tc", irq, 0);
      @(negedge clk);
      chk(tbe == 1'b1, "R5 tbe low for one cycle", tbe, 1);
      rx_byte(32, 1'b0, b, t, s);
      chk(b == 8'hA5, "R2 data bits lsb first", b, 8'hA5);
      chk(s == 1'b1, "R2 stop bit high", s, 1);
      wait_idle();
   endtask

   task automatic t_fraction();
      int low = 0;
      int t0;
      int g = 0;
      @(negedge clk);
      baud_div = 16'h0028;
      write_byte(8'h01);
      while (txd !== 1'b0 && g < 5000) begin
         @(negedge clk);
         g++;
      end
      t0 = cyc;
      while (txd == 1'b0 && low < 5000) begin
         low++;
         @(negedge clk);
      end
      chk(low == 40, "R3 bit time with fraction", low, 40);
      g = 0;
      while (tc !== 1'b1 && g < 5000) begin
         @(negedge clk);
         g++;
      end
      chk(cyc - t0 == 400, "R3 frame time with fraction", cyc - t0, 400);
      @(negedge clk);
      baud_div = 16'h0020;
   endtask

   task automatic t_back_to_back();
      logic [7:0] b;
      int t1, t2;
      logic s;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'h33;
      @(negedge clk);
      wr_data = 8'hCC;
      @(negedge clk);
      wr_en = 1'b0;
      t1 = cyc;
      chk(txd == 1'b0, "R6 first frame started", txd, 0);
      chk(tbe == 1'b0, "R6 second byte held", tbe, 0);
      rx_byte(32, 1'b0, b, t2, s);
      chk(b == 8'h33, "R6 first byte", b, 8'h33);
      chk(tbe == 1'b0, "R6 buffer held to frame end", tbe, 0);
      rx_byte(32, 1'b0, b, t2, s);
      chk(b == 8'hCC, "R6 second byte", b, 8'hCC);
      chk(t2 - t1 == 320, "R6 no gap between frames", t2 - t1, 320);
      chk(tbe == 1'b1, "R5 tbe set after load", tbe, 1);
      wait_idle();
   endtask

   task automatic t_stop_codes();
      int exp_len[4] = '{320, 304, 352, 336};
      for (int c = 0; c < 4; c++) begin
         int t0;
         int g = 0;
         wait_idle();
         stop_sel = 2'(c);
         write_byte(8'hFF);
         while (txd !== 1'b0 && g < 5000) begin
            @(negedge clk);
            g++;
         end
         t0 = cyc;
         g = 0;
         while (tc !== 1'b1 && g < 5000) begin
            @(negedge clk);
            g++;
         end
         chk(cyc - t0 == exp_len[c], $sformatf("R8 frame time stop code %0d", c),
             cyc - t0, exp_len[c]);
      end
      wait_idle();
      stop_sel = 2'b00;
   endtask

   task automatic t_break();
      int low = 0;
      int t0, t2;
      int g = 0;
      logic [7:0] b;
      logic s;
      wait_idle();
      @(negedge clk);
      brk_req = 1'b1;
      wr_en = 1'b1;
      wr_data = 8'hFF;
      @(negedge clk);
      brk_req = 1'b0;
      wr_en = 1'b0;
      while (txd !== 1'b0 && g < 5000) begin
         @(negedge clk);
         g++;
      end
      t0 = cyc;
      while (txd == 1'b0 && low < 5000) begin
         low++;
         @(negedge clk);
      end
      chk(low == 288, "R9 break low time, sent before data", low, 288);
      rx_byte(32, 1'b0, b, t2, s);
      chk(b == 8'hFF, "R9 queued byte after break", b, 8'hFF);
      chk(t2 - t0 == 320, "R9 break stop time", t2 - t0, 320);
      wait_idle();
   endtask

   task automatic t_invert();
      logic [7:0] b;
      int t;
      logic s;
      wait_idle();
      tx_inv = 1'b1;
      @(negedge clk);
      chk(txd == 1'b0, "R10 inverted rest level", txd, 0);
      write_byte(8'h5A);
      rx_byte(32, 1'b1, b, t, s);
      chk(b == 8'h5A, "R10 inverted data", b, 8'h5A);
      wait_idle();
      tx_inv = 1'b0;
   endtask

   task automatic t_disable();
      logic [7:0] b;
      int t, c0;
      logic s;
      bit low_seen = 0;
      wait_idle();
      tx_en = 1'b0;
      write_byte(8'h3C);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (txd == 1'b0) low_seen = 1;
      end
      chk(!low_seen, "R11 no frame while disabled", low_seen, 0);
      chk(tbe == 1'b0, "R11 byte kept in buffer", tbe, 0);
      @(negedge clk);
      tx_en = 1'b1;
      c0 = cyc;
      rx_byte(32, 1'b0, b, t, s);
      chk(b == 8'h3C, "R11 buffered byte sent on enable", b, 8'h3C);
      chk(t - c0 == 321, "R4 idle frame precedes data", t - c0, 321);
      wait_idle();
   endtask

   task automatic t_irq_mask();
      wait_idle();
      irq_en = 1'b0;
      @(negedge clk);
      chk(tc == 1'b1 && irq == 1'b0, "R7 irq masked", irq, 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq == 1'b1, "R7 irq unmasked", irq, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_idle_frame();
      t_data_frame();
      t_fraction();
      t_back_to_back();
      t_stop_codes();
      t_break();
      t_invert();
      t_disable();
      t_irq_mask();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule